// File: doc/BRIEF.md
# Coin-Counting Vending Controller

This block tallies coins presented on a two-bit code, one code per clock cycle. It keeps the credit as a count of half-unit steps. When the credit reaches one and a half units it raises a dispense output. Any credit above the threshold is dropped; the block does not return change. The machine then starts again from zero.

The block has a thin top with two modules under it. A control module holds the counting and dispensing phases. A datapath module holds the credit register and the adder. The control drives the datapath through a small struct of strobes, plus one signal that selects a zero base for the addition. The threshold is a parameter given in half units, with a default of 3. Credit is visible outside the block only through the dispense output.

Top module: `vend_machine`

## Requirements
- R1: A synchronous active-high reset sets the credit to zero and drives dispense low from the first clock edge at which reset is sampled high.
- R2: Coin code 2'b00 means no coin. The credit is unchanged and dispense stays low.
- R3: Coin code 2'b01 adds one half unit (0.50) to the credit.
- R4: Coin code 2'b10 adds two half units (1.00) to the credit.
- R5: Coin code 2'b11 is treated exactly like 2'b00. It adds nothing and the credit holds.
- R6: If a coin sampled at an edge brings the credit to three half units (1.50) or more, dispense is high in the cycle after that edge.
- R7: Dispense is high for exactly one cycle per purchase. Credit above the threshold is discarded, so the credit held is always below three half units.
- R8: A coin presented during the dispense cycle is counted starting from zero credit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coinCode | input | 2 | Coin code: 00 none, 01 half unit, 10 one unit, 11 ignored |
| dispense | output | 1 | High for one cycle when the threshold is reached |

## Verification
Each coin code is sampled at a rising edge. The effect of that coin appears on dispense one cycle later, once the state register has updated. No other register lies on the path. The bench therefore drives each new code on a falling edge. It compares dispense on the next falling edge against a model that applies the same coin one step later. The stimulus is every code sequence of length one to five, each started from reset. This covers every credit value, every code, back-to-back purchases, and coins arriving during the dispense cycle, all with the same one-cycle latency.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    COIN_NONE = 2'b00,
    COIN_HALF = 2'b01,
    COIN_ONE  = 2'b10,
    COIN_BAD  = 2'b11
  } coin_e;

  typedef enum logic {
    ST_COUNT    = 1'b0,
    ST_DISPENSE = 1'b1
  } vend_state_e;

  typedef struct packed {
    logic loadCredit;
    logic clearCredit;
  } vend_strobe_t;

  // Value of a coin code in half-unit steps; the unused code is worth nothing.
  function automatic logic [1:0] coinHalves(input logic [1:0] code);
    case (code)
      COIN_HALF: coinHalves = 2'd1;
      COIN_ONE:  coinHalves = 2'd2;
      default:   coinHalves = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/vend_datapath.sv
module vend_datapath
  import vend_pkg::*;
#(
  parameter int unsigned ThreshHalves = 3,
  localparam int unsigned CreditW = $clog2(ThreshHalves + 1),
  localparam int unsigned SumW = CreditW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         coinCode,
  input  vend_strobe_t       strobes,
  input  logic               baseZero,
  output logic [CreditW-1:0] credit,
  output logic               reached,
  output logic               coinValid
);

  logic [CreditW-1:0] creditQ;
  logic [SumW-1:0]    sumHalves;
  logic [1:0]         halves;

  always_comb begin
    halves    = coinHalves(coinCode);
    coinValid = (halves != 2'd0);
    sumHalves = (baseZero ? SumW'(0) : SumW'(creditQ)) + SumW'(halves);
    reached   = (sumHalves >= SumW'(ThreshHalves));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      creditQ <= '0;
    end else if (strobes.clearCredit) begin
      creditQ <= '0;
    end else if (strobes.loadCredit) begin
      creditQ <= sumHalves[CreditW-1:0];
    end
  end

  assign credit = creditQ;

  // R2 R5
  credit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!coinValid && !baseZero) |=> (creditQ == $past(creditQ)));

  // R7
  credit_below_thresh_chk: assert property (@(posedge clk) disable iff (rst)
    (creditQ < CreditW'(ThreshHalves)));

  // R1
  credit_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (creditQ == '0));

endmodule

// File: rtl/vend_control.sv
module vend_control
  import vend_pkg::*;
#(
  parameter int unsigned ThreshHalves = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reached,
  input  logic         coinValid,
  output vend_strobe_t strobes,
  output logic         baseZero,
  output logic         dispense
);

  vend_state_e state, stateNext;

  assign baseZero = (state == ST_DISPENSE);

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_COUNT: begin
        if (reached) begin
          strobes.clearCredit = 1'b1;
          stateNext           = ST_DISPENSE;
        end else begin
          strobes.loadCredit = coinValid;
        end
      end
      ST_DISPENSE: begin
        if (reached) begin
          strobes.clearCredit = 1'b1;
        end else begin
          strobes.loadCredit = 1'b1;
          stateNext          = ST_COUNT;
        end
      end
      default: stateNext = ST_COUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_COUNT;
    else     state <= stateNext;
  end

  assign dispense = (state == ST_DISPENSE);

  // R6
  reach_dispense_chk: assert property (@(posedge clk) disable iff (rst)
    reached |=> dispense);

  generate
    if (ThreshHalves > 2) begin : g_single_pulse
      // R7
      single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dispense |=> !dispense);
    end
  endgenerate

  // R2
  idle_no_dispense_chk: assert property (@(posedge clk) disable iff (rst)
    (!dispense && !coinValid) |=> !dispense);

endmodule

// File: rtl/vend_machine.sv
module vend_machine
  import vend_pkg::*;
#(
  parameter int unsigned ThreshHalves = 3,
  localparam int unsigned CreditW = $clog2(ThreshHalves + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] coinCode,
  output logic       dispense
);

  vend_strobe_t       strobes;
  logic               baseZero;
  logic               reached;
  logic               coinValid;
  logic [CreditW-1:0] credit;

  vend_datapath #(.ThreshHalves(ThreshHalves)) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .coinCode  (coinCode),
    .strobes   (strobes),
    .baseZero  (baseZero),
    .credit    (credit),
    .reached   (reached),
    .coinValid (coinValid)
  );

  vend_control #(.ThreshHalves(ThreshHalves)) u_control (
    .clk       (clk),
    .rst       (rst),
    .reached   (reached),
    .coinValid (coinValid),
    .strobes   (strobes),
    .baseZero  (baseZero),
    .dispense  (dispense)
  );

  // R8
  restart_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (dispense && (coinHalves(coinCode) < 2'(ThreshHalves)))
      |=> (credit == CreditW'($past(coinHalves(coinCode)))));

  // R3 R4
  accumulate_chk: assert property (@(posedge clk) disable iff (rst)
    (!dispense && ((int'(credit) + int'(coinHalves(coinCode))) < int'(ThreshHalves)))
      |=> (int'(credit) == int'($past(credit)) + int'($past(coinHalves(coinCode)))));

endmodule

// File: tb/tb_vend_machine.sv
`timescale 1ns/1ps
module tb_vend_machine;

  localparam int Thresh = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] coinCode = 2'b00;
  logic       dispense;

  int checks = 0;
  int fails  = 0;
  int mCredit = 0;
  bit mDisp = 1'b0;
  string pendTag = "R1";

  vend_machine #(.ThreshHalves(Thresh)) dut (
    .clk      (clk),
    .rst      (rst),
    .coinCode (coinCode),
    .dispense (dispense)
  );

  always #4 clk = ~clk;

  function automatic int halvesOf(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 0;
  endfunction

  task automatic check(input bit exp, input string tag);
    checks++;
    if (dispense !== exp) begin
      fails++;
      $display("FAIL %s: dispense=%0b expected=%0b", tag, dispense, exp);
    end
  endtask

  // Drive a coin at the falling edge, then check its effect one falling edge later.
  task automatic step(input logic [1:0] c);
    int base;
    int sum;
    string tag;
    coinCode = c;
    base = mDisp ? 0 : mCredit;
    sum  = base + halvesOf(c);
    if (mDisp)            tag = "R8";
    else if (c == 2'b00)  tag = "R2";
    else if (c == 2'b11)  tag = "R5";
    else if (c == 2'b01)  tag = "R3";
    else                  tag = "R4";
    if (sum >= Thresh) begin
      tag = mDisp ? "R8" : "R6";
      mDisp = 1'b1;
      mCredit = 0;
    end else begin
      mDisp = 1'b0;
      mCredit = sum;
    end
    @(negedge clk);
    check(mDisp, tag);
  endtask

  task automatic doReset();
    rst = 1'b1;
    coinCode = 2'b00;
    @(negedge clk);
    check(1'b0, "R1");
    rst = 1'b0;
    mCredit = 0;
    mDisp = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();

    // Exhaustive sweep over all code sequences of length 1 to 5.
    for (int len = 1; len <= 5; len++) begin
      for (int idx = 0; idx < (1 << (2 * len)); idx++) begin
        doReset();
        for (int k = 0; k < len; k++) begin
          step(2'((idx >> (2 * k)) & 3));
        end
        step(2'b00);
      end
    end

    // R7: two single-unit coins give one pulse, excess dropped, next coin restarts.
    doReset();
    step(2'b10);
    step(2'b10);
    step(2'b00);
    check(1'b0, "R7");
    step(2'b01);
    step(2'b10);

    // R1: reset mid-count clears partial credit.
    doReset();
    step(2'b10);
    doReset();
    step(2'b01);
    check(1'b0, "R1");
    step(2'b01);
    check(1'b0, "R1");
    step(2'b01);
    check(1'b1, "R1");

    // R5: a long stretch of ignored codes keeps the partial credit.
    doReset();
    step(2'b01);
    for (int k = 0; k < 8; k++) step(2'b11);
    step(2'b10);
    check(1'b1, "R5");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule